// File: doc/BRIEF.md
# Hierarchical Display Flush Controller

This block holds staged settings for several colour post-processing pipes. Each pipe has three sub-blocks: inverse gamma, colour correction and gamma. Software writes the staged (shadow) settings over a simple synchronous register bus. It then marks which sub-blocks of which pipe it wants committed, in a per-pipe sub-block flush register. Last, it writes the master flush register, and that write arms the commit. On the next frame-boundary strobe, every sub-block whose pipe-group bit is set in the master register and whose own bit is set in its pipe's register copies shadow to active. All of them do so in the same clock cycle, and each emits a one-cycle commit pulse.

The master register also carries the group bits of three other pipeline stages: write-back, compression and the display interface. Each of those stages has a secondary pending register of its own. When its group commits at a strobe, the block pulses a group output and empties that secondary register. Every pending register accumulates by OR. A clear-all write empties all of them.

Top module: `disp_flush_ctrl`

## Requirements
- R1: After reset, every pending register reads zero, every active setting is zero and no commit pulse is asserted.
- R2: A write to pipe n's sub-block flush register (byte address 0x13C + 4*n) ORs into that pipe's pending mask. Only bit 2 (inverse gamma), bit 4 (colour correction) and bit 5 (gamma) are kept. Any other written bit is ignored and reads back as zero.
- R3: A write to the master flush register (0x018) ORs into the master pending mask. Only bit 16 (write-back), bit 22 (compression), bit 29 (post-processing pipes) and bit 31 (interface) are kept. Reads return the pending mask.
- R4: At a clock edge where frame_strobe is high, master bit 29 is pending and pipe n has sub-block s pending, the active setting (n,s) takes the shadow value. sub_commit[3*n+s] is high for exactly the following cycle. Sub-block index s is 0 for inverse gamma, 1 for colour correction and 2 for gamma. Shadow (n,s) is at address 0x200 + 16*n + 4*s.
- R5: A pipe whose sub-block pending mask is zero is left unchanged and pulses nothing, even when master bit 29 commits.
- R6: At a strobe without master bit 29 pending, no sub-block commits and every sub-block pending mask is kept.
- R7: After a strobe, the master pending mask reads zero. When bit 29 was pending, every pipe's sub-block pending mask reads zero.
- R8: Writing 1 to bit 0 at the clear address (0x01C) zeroes the master mask, every sub-block mask and the three secondary registers. A later strobe then commits nothing.
- R9: The secondary pending registers are compression at 0x104, write-back at 0x108 and interface at 0x110, and each accumulates by OR. At a strobe with master bit 16, 22 or 31 pending, grp_commit bit 0 (write-back), bit 1 (compression) or bit 2 (interface) pulses for one cycle, and the matching secondary register clears. The other secondary registers are kept.
- R10: The active settings change only at a strobe edge. A master write on its own does not alter them.
- R11: Sub-blocks of different pipes that qualify at the same strobe all commit and pulse in the same cycle.
- R12: A read returns its data on bus_rdata in the cycle after bus_rd. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| frame_strobe | input | 1 | Frame-boundary commit strobe |
| sub_commit | output | NPIPE*3 | Per sub-block commit pulse, index 3*pipe+sub |
| grp_commit | output | 3 | Write-back, compression, interface group pulses |
| active_cfg | output | NPIPE*3*CFG_W | Active settings, entry 3*pipe+sub |

## Verification
The assertions watch every cycle for four properties. A sub-block pulse or group pulse appears only right after a strobe, and a sub-block pulse only with master bit 29 pending. The active settings hold between strobes. The master mask is empty after a strobe and never carries an undefined bit. Only the directed scenarios can show the rest: which sub-blocks commit for a given pair of master and pipe masks, and what value each one takes. They also cover masks kept across strobes, the selective clearing of the secondary registers, clear-all, and the masking of undefined bits on readback.

// File: rtl/flush_pkg.sv
package flush_pkg;
  localparam int NSUB        = 3;
  localparam int DW          = 32;
  // master group bit positions
  localparam int MST_WB_BIT   = 16;
  localparam int MST_CMP_BIT  = 22;
  localparam int MST_PIPE_BIT = 29;
  localparam int MST_INTF_BIT = 31;
  localparam logic [DW-1:0] MST_MASK = (32'h1 << MST_WB_BIT) | (32'h1 << MST_CMP_BIT) |
                                       (32'h1 << MST_PIPE_BIT) | (32'h1 << MST_INTF_BIT);
  // sub-block bit positions within a pipe flush register
  localparam logic [DW-1:0] SUB_MASK = 32'h0000_0034;
  // address map
  localparam int A_MASTER   = 'h018;
  localparam int A_CLEAR    = 'h01C;
  localparam int A_CMP      = 'h104;
  localparam int A_WB       = 'h108;
  localparam int A_INTF     = 'h110;
  localparam int A_SUB_BASE = 'h13C;
  localparam int A_SHD_BASE = 'h200;
  localparam int PIPE_STRIDE = 16;

  typedef enum logic [1:0] {
    SUB_INVGAM = 2'd0,
    SUB_CCORR  = 2'd1,
    SUB_GAMMA  = 2'd2
  } sub_e;

  function automatic int sub_bit(input int s);
    case (s)
      0:       return 2;
      1:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/flush_addr_dec.sv
module flush_addr_dec
  import flush_pkg::*;
#(
  parameter int NPIPE  = 4,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit_master,
  output logic                  hit_clear,
  output logic                  hit_cmp,
  output logic                  hit_wb,
  output logic                  hit_intf,
  output logic [NPIPE-1:0]      hit_sub,
  output logic [NPIPE*NSUB-1:0] hit_shd
);
  assign hit_master = (addr == ADDR_W'(A_MASTER));
  assign hit_clear  = (addr == ADDR_W'(A_CLEAR));
  assign hit_cmp    = (addr == ADDR_W'(A_CMP));
  assign hit_wb     = (addr == ADDR_W'(A_WB));
  assign hit_intf   = (addr == ADDR_W'(A_INTF));

  for (genvar n = 0; n < NPIPE; n++) begin : g_pipe
    assign hit_sub[n] = (addr == ADDR_W'(A_SUB_BASE + 4 * n));
    for (genvar s = 0; s < NSUB; s++) begin : g_sub
      assign hit_shd[n*NSUB+s] = (addr == ADDR_W'(A_SHD_BASE + PIPE_STRIDE * n + 4 * s));
    end
  end
endmodule

// File: rtl/flush_master_reg.sv
module flush_master_reg
  import flush_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic          clear,
  input  logic          wr_master,
  input  logic          wr_cmp,
  input  logic          wr_wb,
  input  logic          wr_intf,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] master_pend,
  output logic [DW-1:0] cmp_pend,
  output logic [DW-1:0] wb_pend,
  output logic [DW-1:0] intf_pend,
  output logic [2:0]    grp_pulse
);
  logic go_wb, go_cmp, go_intf;
  assign go_wb   = strobe & master_pend[MST_WB_BIT];
  assign go_cmp  = strobe & master_pend[MST_CMP_BIT];
  assign go_intf = strobe & master_pend[MST_INTF_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      master_pend <= '0;
      cmp_pend    <= '0;
      wb_pend     <= '0;
      intf_pend   <= '0;
      grp_pulse   <= '0;
    end else begin
      grp_pulse <= {go_intf, go_cmp, go_wb};
      if (clear) begin
        master_pend <= '0;
        cmp_pend    <= '0;
        wb_pend     <= '0;
        intf_pend   <= '0;
      end else begin
        master_pend <= (strobe ? '0 : master_pend) | (wr_master ? (wdata & MST_MASK) : '0);
        cmp_pend    <= (go_cmp  ? '0 : cmp_pend)  | (wr_cmp  ? wdata : '0);
        wb_pend     <= (go_wb   ? '0 : wb_pend)   | (wr_wb   ? wdata : '0);
        intf_pend   <= (go_intf ? '0 : intf_pend) | (wr_intf ? wdata : '0);
      end
    end
  end
endmodule

// File: rtl/pipe_flush_slice.sv
module pipe_flush_slice
  import flush_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strobe,
  input  logic                  pipe_go,
  input  logic                  clear,
  input  logic                  wr_sub,
  input  logic [NSUB-1:0]       wr_shd,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         sub_pend,
  output logic [NSUB*CFG_W-1:0] shadow,
  output logic [NSUB*CFG_W-1:0] active,
  output logic [NSUB-1:0]       pulse
);
  logic          commit_all;
  logic [DW-1:0] consumed;
  assign commit_all = strobe & pipe_go;
  assign consumed   = commit_all ? sub_pend : '0;

  always_ff @(posedge clk) begin
    if (rst)        sub_pend <= '0;
    else if (clear) sub_pend <= '0;
    else            sub_pend <= (sub_pend & ~consumed) | (wr_sub ? (wdata & SUB_MASK) : '0);
  end

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    logic go;
    assign go = commit_all & sub_pend[sub_bit(s)];

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[s*CFG_W +: CFG_W] <= '0;
        active[s*CFG_W +: CFG_W] <= '0;
        pulse[s]                 <= 1'b0;
      end else begin
        if (wr_shd[s]) shadow[s*CFG_W +: CFG_W] <= wdata[CFG_W-1:0];
        if (go)        active[s*CFG_W +: CFG_W] <= shadow[s*CFG_W +: CFG_W];
        pulse[s] <= go;
      end
    end
  end
endmodule

// File: rtl/disp_flush_ctrl.sv
module disp_flush_ctrl
  import flush_pkg::*;
#(
  parameter int NPIPE  = 4,
  parameter int CFG_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic                        frame_strobe,
  output logic [NPIPE*3-1:0]          sub_commit,
  output logic [2:0]                  grp_commit,
  output logic [NPIPE*3*CFG_W-1:0]    active_cfg
);
  localparam int NENT = NPIPE * NSUB;

  logic hit_master, hit_clear, hit_cmp, hit_wb, hit_intf;
  logic [NPIPE-1:0] hit_sub;
  logic [NENT-1:0]  hit_shd;
  logic             do_clear;
  logic [DW-1:0]    master_pend, cmp_pend, wb_pend, intf_pend;
  logic [NPIPE-1:0][DW-1:0]         sub_pend;
  logic [NPIPE-1:0][NSUB*CFG_W-1:0] shd_pk, act_pk;
  logic [NPIPE-1:0][NSUB-1:0]       pulse_pk;
  logic [DW-1:0]    rd_mux;

  flush_addr_dec #(.NPIPE(NPIPE), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit_master(hit_master), .hit_clear(hit_clear),
    .hit_cmp(hit_cmp), .hit_wb(hit_wb), .hit_intf(hit_intf),
    .hit_sub(hit_sub), .hit_shd(hit_shd)
  );

  assign do_clear = bus_wr & hit_clear & bus_wdata[0];

  flush_master_reg u_mst (
    .clk(clk), .rst(rst), .strobe(frame_strobe), .clear(do_clear),
    .wr_master(bus_wr & hit_master), .wr_cmp(bus_wr & hit_cmp),
    .wr_wb(bus_wr & hit_wb), .wr_intf(bus_wr & hit_intf),
    .wdata(bus_wdata), .master_pend(master_pend), .cmp_pend(cmp_pend),
    .wb_pend(wb_pend), .intf_pend(intf_pend), .grp_pulse(grp_commit)
  );

  for (genvar n = 0; n < NPIPE; n++) begin : g_pipe
    pipe_flush_slice #(.CFG_W(CFG_W)) u_slice (
      .clk(clk), .rst(rst), .strobe(frame_strobe),
      .pipe_go(master_pend[MST_PIPE_BIT]), .clear(do_clear),
      .wr_sub(bus_wr & hit_sub[n]), .wr_shd({NSUB{bus_wr}} & hit_shd[n*NSUB +: NSUB]),
      .wdata(bus_wdata), .sub_pend(sub_pend[n]), .shadow(shd_pk[n]),
      .active(act_pk[n]), .pulse(pulse_pk[n])
    );
    assign active_cfg[n*NSUB*CFG_W +: NSUB*CFG_W] = act_pk[n];
    assign sub_commit[n*NSUB +: NSUB]             = pulse_pk[n];
  end

  always_comb begin
    rd_mux = '0;
    if (hit_master) rd_mux = master_pend;
    if (hit_cmp)    rd_mux = cmp_pend;
    if (hit_wb)     rd_mux = wb_pend;
    if (hit_intf)   rd_mux = intf_pend;
    for (int n = 0; n < NPIPE; n++) begin
      if (hit_sub[n]) rd_mux = sub_pend[n];
      for (int s = 0; s < NSUB; s++) begin
        if (hit_shd[n*NSUB+s]) rd_mux = DW'(shd_pk[n][s*CFG_W +: CFG_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/disp_flush_ctrl_chk.sv
module disp_flush_ctrl_chk
  import flush_pkg::*;
#(
  parameter int NPIPE = 4,
  parameter int CFG_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_wr,
  input logic                     frame_strobe,
  input logic [31:0]              master_pend,
  input logic [NPIPE*3-1:0]       sub_commit,
  input logic [2:0]               grp_commit,
  input logic [NPIPE*3*CFG_W-1:0] active_cfg
);
  assert_pulse_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (|sub_commit) |-> $past(frame_strobe));

  assert_pulse_needs_master_R5: assert property (@(posedge clk) disable iff (rst)
    (|sub_commit) |-> $past(master_pend[MST_PIPE_BIT]));

  assert_active_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_strobe) |-> $stable(active_cfg));

  assert_master_empty_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_strobe) && !$past(bus_wr)) |-> (master_pend == 32'h0));

  assert_grp_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (|grp_commit) |-> $past(frame_strobe));

  assert_master_defined_R3: assert property (@(posedge clk) disable iff (rst)
    (master_pend & ~MST_MASK) == 32'h0);
endmodule

bind disp_flush_ctrl disp_flush_ctrl_chk #(.NPIPE(NPIPE), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .frame_strobe(frame_strobe),
  .master_pend(master_pend), .sub_commit(sub_commit), .grp_commit(grp_commit),
  .active_cfg(active_cfg)
);

// File: tb/disp_flush_ctrl_tb.sv
`timescale 1ns/1ps
module disp_flush_ctrl_tb;
  localparam int NP = 4;
  localparam int CW = 16;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic frame_strobe = 1'b0;
  logic [NP*3-1:0] sub_commit;
  logic [2:0] grp_commit;
  logic [NP*3*CW-1:0] active_cfg;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  disp_flush_ctrl #(.NPIPE(NP), .CFG_W(CW), .ADDR_W(AW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] act_of(input int n, input int s);
    return 32'(active_cfg[(n*3+s)*CW +: CW]);
  endfunction

  function automatic logic [AW-1:0] a_sub(input int n);
    return AW'(12'h13C + 4*n);
  endfunction

  function automatic logic [AW-1:0] a_shd(input int n, input int s);
    return AW'(12'h200 + 16*n + 4*s);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // pulse strobe; on return we are one cycle after the commit edge
  task automatic strobe(output logic [NP*3-1:0] pls, output logic [2:0] gp);
    @(negedge clk);
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
    pls = sub_commit;
    gp  = grp_commit;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 sub_commit", 32'(sub_commit), 32'h0);
    chk("R1 grp_commit", 32'(grp_commit), 32'h0);
    chk("R1 active", 32'(|active_cfg), 32'h0);
    rd(12'h018, d); chk("R1 master", d, 32'h0);
    rd(a_sub(0), d); chk("R1 sub0", d, 32'h0);
  endtask

  task automatic t_sub_accum();
    logic [31:0] d;
    wr(a_sub(1), 32'h0000_0004);
    wr(a_sub(1), 32'hFFFF_FFC0 | 32'h10);
    rd(a_sub(1), d); chk("R2 or-accumulate masked", d, 32'h14);
    wr(12'h01C, 32'h1);
    rd(a_sub(1), d); chk("R8 clear sub", d, 32'h0);
  endtask

  task automatic t_master_bits();
    logic [31:0] d;
    wr(12'h018, 32'h0000_FFFF);
    wr(12'h018, 32'hFFFF_0000);
    rd(12'h018, d); chk("R3 master masked", d, 32'hA041_0000);
    wr(12'h01C, 32'h1);
    rd(12'h018, d); chk("R8 clear master", d, 32'h0);
  endtask

  task automatic t_commit();
    logic [31:0] d;
    logic [NP*3-1:0] p;
    logic [2:0] g;
    for (int s = 0; s < 3; s++) wr(a_shd(0, s), 32'h1000 + 32'(s));
    wr(a_shd(2, 2), 32'hBEEF);
    rd(a_shd(2, 2), d); chk("R12 shadow read", d, 32'hBEEF);
    wr(a_sub(0), 32'h34);
    wr(a_sub(2), 32'h20);
    wr(12'h018, 32'h2000_0000);
    repeat (3) @(negedge clk);
    chk("R10 no change before strobe", 32'(|active_cfg), 32'h0);
    strobe(p, g);
    chk("R11 pulses same cycle", 32'(p), 32'h0000_0107);
    chk("R4 p0 inv", act_of(0, 0), 32'h1000);
    chk("R4 p0 cc", act_of(0, 1), 32'h1001);
    chk("R4 p0 gam", act_of(0, 2), 32'h1002);
    chk("R11 p2 gam", act_of(2, 2), 32'hBEEF);
    chk("R5 p1 untouched", act_of(1, 1), 32'h0);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(sub_commit), 32'h0);
    rd(12'h018, d); chk("R7 master cleared", d, 32'h0);
    rd(a_sub(0), d); chk("R7 sub0 consumed", d, 32'h0);
    rd(a_sub(2), d); chk("R7 sub2 consumed", d, 32'h0);
  endtask

  task automatic t_master_only();
    logic [NP*3-1:0] p;
    logic [2:0] g;
    wr(a_shd(1, 1), 32'h7777);
    wr(12'h018, 32'h2000_0000);
    strobe(p, g);
    chk("R5 no pulse master-only", 32'(p), 32'h0);
    chk("R5 p1 active kept", act_of(1, 1), 32'h0);
    chk("R5 p0 active kept", act_of(0, 1), 32'h1001);
  endtask

  task automatic t_no_master();
    logic [31:0] d;
    logic [NP*3-1:0] p;
    logic [2:0] g;
    wr(a_shd(3, 0), 32'h3333);
    wr(a_sub(3), 32'h04);
    strobe(p, g);
    chk("R6 no pulse without master", 32'(p), 32'h0);
    rd(a_sub(3), d); chk("R6 sub3 kept", d, 32'h04);
    wr(12'h018, 32'h0001_0000);
    strobe(p, g);
    chk("R6 no sub pulse wb-only", 32'(p), 32'h0);
    chk("R9 wb group pulse", 32'(g), 32'h1);
    rd(a_sub(3), d); chk("R6 sub3 still kept", d, 32'h04);
    wr(12'h018, 32'h2000_0000);
    strobe(p, g);
    chk("R4 p3 inv pulse", 32'(p), 32'h0000_0200);
    chk("R4 p3 inv active", act_of(3, 0), 32'h3333);
  endtask

  task automatic t_secondary();
    logic [31:0] d;
    logic [NP*3-1:0] p;
    logic [2:0] g;
    wr(12'h108, 32'h50); wr(12'h108, 32'h05);
    wr(12'h104, 32'h66);
    wr(12'h110, 32'h77);
    rd(12'h108, d); chk("R9 wb accumulate", d, 32'h55);
    wr(12'h018, 32'h8040_0000);
    strobe(p, g);
    chk("R9 cmp+intf pulse", 32'(g), 32'h6);
    rd(12'h104, d); chk("R9 cmp cleared", d, 32'h0);
    rd(12'h110, d); chk("R9 intf cleared", d, 32'h0);
    rd(12'h108, d); chk("R9 wb kept", d, 32'h55);
  endtask

  task automatic t_clear_all();
    logic [31:0] d;
    logic [NP*3-1:0] p;
    logic [2:0] g;
    wr(a_shd(1, 2), 32'h4444);
    wr(a_sub(1), 32'h20);
    wr(12'h018, 32'h2001_0000);
    wr(12'h01C, 32'h1);
    rd(12'h108, d); chk("R8 wb cleared", d, 32'h0);
    rd(a_sub(1), d); chk("R8 sub1 cleared", d, 32'h0);
    strobe(p, g);
    chk("R8 no sub commit", 32'(p), 32'h0);
    chk("R8 no group commit", 32'(g), 32'h0);
    chk("R8 p1 gam kept", act_of(1, 2), 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h7FC, d); chk("R12 unmapped zero", d, 32'h0);
    rd(12'h140, d); chk("R12 sub1 addr zero", d, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sub_accum();
    t_master_bits();
    t_commit();
    t_master_only();
    t_no_master();
    t_secondary();
    t_clear_all();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule